// File: doc/BRIEF.md
# Split-Transaction Bus Scheduler

This block is the central arbiter for an on-chip fabric built from three shared buses: an address bus (A), a data bus (D) and a packet bus (P). Every master module owns a dedicated request word. The word names the set of buses the transfer needs, how many cycles it occupies them, which slave module it targets, and a transaction type. Every slave module owns a ready line that it raises whenever it can take a new transaction.

In every cycle the scheduler looks at all pending requests and all ready lines. It selects one request whose buses are all idle and whose target is ready, and reserves those buses for the stated number of cycles. In the same cycle it grants the master, so the master can enable its pre-loaded output register onto the buses. Also in that cycle it tells the target slave the transaction type and the ID of the requesting master.

Each bus has its own reservation counter. A transfer that needs only the address bus can therefore start while another transaction still holds the data bus. The request word and its grant behave as a valid/ready pair. A master keeps its request valid and its fields stable until it sees the grant. Back-pressure is the absence of a grant, which comes from a busy bus, an unready target or a lost arbitration. The grant is combinational from the current request and reservation state. Slave ready lines are plain control inputs.

Top module: `split_bus_sched`

## Requirements
- R1: Request fields per master: the bus set is 3 bits (bit 0 address bus, bit 1 data bus, bit 2 packet bus), the length is 4 bits, the target is a slave index, and the type is a 3-bit code. The length gives the number of cycles, and a length of 0 is treated as 1.
- R2: A master is granted only while its request is valid, none of the buses it names is reserved, and the ready line of its target slave is high.
- R3: At most one master is granted in any cycle.
- R4: A transfer granted in cycle t with length L holds each of its buses in cycles t to t+L-1. The bus can be granted again from cycle t+L.
- R5: In the grant cycle, only the target slave sees its request strobe high, together with the master's type code and the granting master's index. All other slave strobes, types and sources are 0.
- R6: A request that needs only the address bus is granted while a different transaction still holds the data bus.
- R7: Rotating priority: the search for a winner starts at the master after the last one granted and wraps around. Whenever some request is eligible, one is granted.
- R8: After reset no bus is reserved and the search starts at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req_vld | input | N_MST | Request valid, one bit per master |
| mst_req_bus | input | 3*N_MST | Needed bus set per master |
| mst_req_len | input | LEN_W*N_MST | Transfer length in cycles per master |
| mst_req_tgt | input | SID_W*N_MST | Target slave index per master |
| mst_req_type | input | TYPE_W*N_MST | Transaction type per master |
| slv_rdy | input | N_SLV | Slave can accept a transaction |
| mst_grant | output | N_MST | Grant, one bit per master |
| slv_req_vld | output | N_SLV | New-transaction strobe per slave |
| slv_req_type | output | TYPE_W*N_SLV | Transaction type forwarded to each slave |
| slv_req_src | output | MID_W*N_SLV | Requesting master index forwarded to each slave |

## Verification
The embedded assertions check several rules in every cycle. They check that there is never more than one grant, that a grant always has a valid request and a ready target, and that no bus is booked while its counter is still running. They also check that each counter steps down by one, that the number of slave strobes equals the number of grants, and that an eligible request never goes unserved. The exact rotation order, the exact hold length including the zero-length case, and the overlap of an address-only transfer with a long data transfer need ordered stimulus. A waiting request that is held off by an unready slave also needs ordered stimulus. The bench's reference model covers these cases cycle by cycle, in directed sequences and in a long random run.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NBUS  = 3;
  localparam int LEN_W = 4;
  typedef enum int unsigned {BUS_A = 0, BUS_D = 1, BUS_P = 2} bus_e;
endpackage

// File: rtl/bus_resv.sv
module bus_resv
  import sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             busy
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] hold;

  // the grant cycle itself counts; zero length behaves as one
  assign hold = (len == '0) ? '0 : len - 1'b1;
  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= hold;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  p_no_double_book_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  elig,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] win,
  output logic          any
);
  logic [IW-1:0] ptr;
  int unsigned   idx;

  always_comb begin
    gnt = '0;
    win = '0;
    any = 1'b0;
    idx = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!any && elig[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        win      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr <= '0;
    else if (any) ptr <= (int'(win) == N - 1) ? '0 : win + 1'b1;
  end

  p_work_conserving_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (elig != '0) |-> (gnt != '0));
  p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~elig) == '0);
endmodule

// File: rtl/split_bus_sched.sv
module split_bus_sched
  import sched_pkg::*;
#(
  parameter int N_MST  = 4,
  parameter int N_SLV  = 4,
  parameter int TYPE_W = 3,
  localparam int SID_W = (N_SLV > 1) ? $clog2(N_SLV) : 1,
  localparam int MID_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MST-1:0]        mst_req_vld,
  input  logic [NBUS*N_MST-1:0]   mst_req_bus,
  input  logic [LEN_W*N_MST-1:0]  mst_req_len,
  input  logic [SID_W*N_MST-1:0]  mst_req_tgt,
  input  logic [TYPE_W*N_MST-1:0] mst_req_type,
  input  logic [N_SLV-1:0]        slv_rdy,
  output logic [N_MST-1:0]        mst_grant,
  output logic [N_SLV-1:0]        slv_req_vld,
  output logic [TYPE_W*N_SLV-1:0] slv_req_type,
  output logic [MID_W*N_SLV-1:0]  slv_req_src
);
  logic [NBUS-1:0]   bus_busy;
  logic [N_MST-1:0]  elig;
  logic [MID_W-1:0]  win;
  logic              any;
  logic [NBUS-1:0]   w_bus;
  logic [LEN_W-1:0]  w_len;
  logic [SID_W-1:0]  w_tgt;
  logic [TYPE_W-1:0] w_type;
  logic [N_MST-1:0]  tgt_ok;

  // eligibility per master: valid, buses idle, target in range and ready
  for (genvar i = 0; i < N_MST; i++) begin : g_mst
    logic [NBUS-1:0]  need;
    logic [SID_W-1:0] tgt;
    assign need = mst_req_bus[i*NBUS +: NBUS];
    assign tgt  = mst_req_tgt[i*SID_W +: SID_W];
    assign tgt_ok[i] = (int'(tgt) < N_SLV) && slv_rdy[tgt];
    assign elig[i]   = mst_req_vld[i] && ((need & bus_busy) == '0) && tgt_ok[i];

    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mst_grant[i] |-> (mst_req_vld[i] && tgt_ok[i]));
  end

  rr_pick #(.N(N_MST)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .elig  (elig),
    .gnt   (mst_grant),
    .win   (win),
    .any   (any)
  );

  assign w_bus  = mst_req_bus[win*NBUS +: NBUS];
  assign w_len  = mst_req_len[win*LEN_W +: LEN_W];
  assign w_tgt  = mst_req_tgt[win*SID_W +: SID_W];
  assign w_type = mst_req_type[win*TYPE_W +: TYPE_W];

  // one reservation counter per shared bus
  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    bus_resv u_resv (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (any && w_bus[b]),
      .len   (w_len),
      .busy  (bus_busy[b])
    );
  end

  // forward type and source to the chosen slave in the grant cycle
  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    logic hit;
    assign hit = any && (int'(w_tgt) == s);
    assign slv_req_vld[s] = hit;
    assign slv_req_type[s*TYPE_W +: TYPE_W] = hit ? w_type : '0;
    assign slv_req_src[s*MID_W +: MID_W]    = hit ? win    : '0;
  end

  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_grant));
  p_target_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slv_req_vld) == $countones(mst_grant));
endmodule

// File: tb/split_bus_sched_bench.sv
module split_bus_sched_bench;
  localparam int NM = 4, NS = 4, LW = 4, TW = 3, SW = 2, MW = 2, NB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NM-1:0]  r_vld;
  logic [NB-1:0]  r_bus [NM];
  logic [LW-1:0]  r_len [NM];
  logic [SW-1:0]  r_tgt [NM];
  logic [TW-1:0]  r_typ [NM];
  logic [NS-1:0]  rdy;

  logic [NB*NM-1:0] f_bus;
  logic [LW*NM-1:0] f_len;
  logic [SW*NM-1:0] f_tgt;
  logic [TW*NM-1:0] f_typ;
  logic [NM-1:0]    grant;
  logic [NS-1:0]    s_vld;
  logic [TW*NS-1:0] s_typ;
  logic [MW*NS-1:0] s_src;

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      f_bus[i*NB +: NB] = r_bus[i];
      f_len[i*LW +: LW] = r_len[i];
      f_tgt[i*SW +: SW] = r_tgt[i];
      f_typ[i*TW +: TW] = r_typ[i];
    end
  end

  split_bus_sched u_split_bus_sched (
    .clk(clk), .rst_n(rst_n),
    .mst_req_vld(r_vld), .mst_req_bus(f_bus), .mst_req_len(f_len),
    .mst_req_tgt(f_tgt), .mst_req_type(f_typ), .slv_rdy(rdy),
    .mst_grant(grant), .slv_req_vld(s_vld), .slv_req_type(s_typ),
    .slv_req_src(s_src)
  );

  int checks = 0, failures = 0;
  int busy_m [NB];
  int ptr_m = 0;
  bit done = 0;

  task automatic req(int i, logic [2:0] bus, int len, int tgt, int typ);
    r_vld[i] = 1'b1; r_bus[i] = bus; r_len[i] = LW'(len);
    r_tgt[i] = SW'(tgt); r_typ[i] = TW'(typ);
  endtask

  // compare at mid-cycle, advance model at the edge, retire granted requests
  task automatic step(string tag);
    logic [NM-1:0] eg;
    int w;
    bit found, ok;
    #1;
    eg = '0; w = 0; found = 0;
    for (int k = 0; k < NM; k++) begin
      int idx;
      idx = (ptr_m + k) % NM;
      ok = r_vld[idx] && rdy[r_tgt[idx]];
      for (int b = 0; b < NB; b++) if (r_bus[idx][b] && busy_m[b] > 0) ok = 0;
      if (!found && ok) begin found = 1; w = idx; eg[idx] = 1'b1; end
    end
    checks++;
    if (grant !== eg) begin
      failures++;
      $display("FAIL %s grant: actual=%b expected=%b at %0t", tag, grant, eg, $time);
    end
    for (int s = 0; s < NS; s++) begin
      logic ev; logic [TW-1:0] et; logic [MW-1:0] es;
      ev = found && (int'(r_tgt[w]) == s);
      et = ev ? r_typ[w] : '0;
      es = ev ? MW'(w) : '0;
      checks++;
      if (s_vld[s] !== ev || s_typ[s*TW +: TW] !== et || s_src[s*MW +: MW] !== es) begin
        failures++;
        $display("FAIL R5 (%s) slave %0d: actual=%b/%0d/%0d expected=%b/%0d/%0d",
                 tag, s, s_vld[s], s_typ[s*TW +: TW], s_src[s*MW +: MW], ev, et, es);
      end
    end
    for (int b = 0; b < NB; b++) begin
      if (found && r_bus[w][b]) busy_m[b] = (r_len[w] == 0) ? 0 : int'(r_len[w]) - 1;
      else if (busy_m[b] > 0) busy_m[b]--;
    end
    if (found) ptr_m = (w + 1) % NM;
    @(posedge clk); #1;
    for (int i = 0; i < NM; i++) if (eg[i]) r_vld[i] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    r_vld = '0; rdy = '1;
    for (int i = 0; i < NM; i++) begin r_bus[i] = '0; r_len[i] = '0; r_tgt[i] = '0; r_typ[i] = '0; end
    for (int b = 0; b < NB; b++) busy_m[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: idle after reset, no grant
    step("R8");
    // R8/R7: all four contend on D with length 1; search starts at 0 then rotates
    for (int i = 0; i < NM; i++) req(i, 3'b010, 1, 0, i + 1);
    repeat (5) step("R7");
    // R4: length 3 holds D for three cycles; length 0 holds one
    req(0, 3'b010, 3, 1, 2); step("R4");
    req(1, 3'b010, 0, 2, 5); repeat (3) step("R4");
    req(2, 3'b010, 1, 3, 6); repeat (2) step("R4");
    // R1: packet and all-bus sets, length 15
    req(3, 3'b111, 15, 0, 7); step("R1");
    req(0, 3'b100, 2, 1, 1); repeat (16) step("R1");
    // R6: address-only overlaps a long data transfer
    req(1, 3'b010, 6, 0, 3); step("R6");
    req(2, 3'b001, 1, 1, 4); step("R6");
    req(3, 3'b001, 2, 2, 5); repeat (6) step("R6");
    // R2: target not ready holds the request off
    rdy[2] = 1'b0;
    req(0, 3'b001, 1, 2, 6); repeat (3) step("R2");
    rdy[2] = 1'b1; repeat (2) step("R2");
    // R3/R2/R7: random traffic, masters hold requests until granted
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NM; i++)
        if (!r_vld[i] && ($urandom % 3 == 0))
          req(i, 3'($urandom), int'($urandom % 16), int'($urandom % NS), int'($urandom % 8));
      rdy = NS'($urandom) | NS'($urandom);
      step("R3");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule